// File: doc/BRIEF.md
# Timer Interrupt Router with Legacy Takeover

This block sits between a bank of timer channels and the interrupt fabric. Each channel raises a one-cycle fire request when its comparator matches. The router turns that request into a delivery of one of three kinds, chosen by the channel's configuration. A level delivery sets a sticky status bit and holds an interrupt line high. An edge delivery produces a one-cycle pulse on the line and leaves the status bit clear. A message delivery posts a 32-bit data word to a 32-bit address through a valid/ready request port and does not touch any line.

When the legacy takeover bit is set, channel 0 is forced onto line 0 and channel 1 onto line 8, whatever their route fields say. The external interval-timer and real-time-clock inputs, which otherwise pass onto those two lines, are shut out. An enable output tells the external interval timer to stand down while the takeover is active. Software clears level status bits by writing ones. Clearing a channel, disabling it, turning off the global enable, or switching the channel into message delivery also removes any interrupt the channel is driving.

Top module: `tir_router`

## Requirements
- R1: After reset, every interrupt line is low, every status bit is clear, the interval-timer enable output is high and no message request is valid.
- R2: A fire on an enabled, non-message, level channel (level bit 1) while the global enable is on sets that channel's status bit. It drives the routed line high one cycle after the fire, and the line stays high until the channel is deasserted.
- R3: A fire on an enabled, non-message, edge channel (level bit 0) drives the routed line high for exactly one cycle and leaves the status bit clear.
- R4: Outside legacy takeover, channel c drives the line numbered by its route field, bits [c*RW +: RW] of the route bus. Lines whose number is NLINES or above are not driven. Level and edge drives from several channels on one line are ORed.
- R5: In legacy takeover, channel 0 drives line 0 and channel 1 drives line 8, regardless of their route fields. Other channels keep their route fields.
- R6: A clear request, a low channel enable or a low global enable clears the channel's status bit and drops its drive in the next cycle. A fire in that same cycle is ignored.
- R7: A status write with a one in bit c clears status bit c only if that bit is currently set. A zero bit leaves its status bit unchanged.
- R8: A fire on an enabled channel with message delivery on leaves the status bit and lines untouched. It posts one message request carrying that channel's address and data inputs as sampled at the fire.
- R9: A rising edge on a channel's message-enable input clears its status bit and drops its line drive in the next cycle.
- R10: Outside legacy takeover, the interval-timer input appears on line 0 and the real-time-clock input on line 8 one cycle later, ORed with channel drives. During takeover both inputs are blocked. The enable output equals the inverse of the takeover bit, one cycle later. On leaving takeover, line 8 follows the real-time-clock level sampled at that edge.
- R11: A valid message request holds its address and data stable until accepted. Each channel holds at most one pending message. A new fire while the slot is full refreshes its payload. Pending messages are issued lowest channel index first, starting two cycles after the fire when the port is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fire_i | input | NCH | Per-channel fire request, one cycle |
| clr_i | input | NCH | Per-channel clear request |
| ch_en_i | input | NCH | Per-channel enable |
| level_i | input | NCH | 1 = level delivery, 0 = edge delivery |
| msg_en_i | input | NCH | Per-channel message delivery enable |
| route_i | input | NCH*RW | Per-channel line number, channel c at [c*RW +: RW] |
| msg_addr_i | input | NCH*32 | Per-channel message address, channel c at [c*32 +: 32] |
| msg_data_i | input | NCH*32 | Per-channel message data, channel c at [c*32 +: 32] |
| glb_en_i | input | 1 | Global interrupt enable |
| legacy_i | input | 1 | Legacy takeover mode |
| pit_in_i | input | 1 | External interval-timer interrupt |
| rtc_in_i | input | 1 | External real-time-clock interrupt |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | NCH | Status write data, write 1 to clear |
| msg_ready_i | input | 1 | Message port ready |
| irq_o | output | NLINES | Interrupt lines |
| sts_o | output | NCH | Per-channel level status |
| pit_en_o | output | 1 | External interval timer enable |
| msg_valid_o | output | 1 | Message request valid |
| msg_addr_o | output | 32 | Message address |
| msg_data_o | output | 32 | Message data |

## Verification
The bench shares line 3 between a level channel and another level channel, then clears one of them. A design that assigned the line instead of ORing it would drop the line while the other channel still holds it. Status writes with ones over clear bits check that no fire is swallowed. A clear issued in the same cycle as a fire catches a design that lets the fire win. Legacy entry and exit with both external inputs high expose a leak of the external inputs during takeover, or a wrong line 8 level on exit. Two channels fire messages together while the port stalls. A design that let the payload move under stall, served the wrong channel first or lost the second request would differ from the cycle model.

// File: rtl/tir_pkg.sv
package tir_pkg;
  localparam int LEG_PIT_LINE = 0;
  localparam int LEG_RTC_LINE = 8;

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] data;
  } msg_t;
endpackage

// File: rtl/tir_chan.sv
module tir_chan (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  input  logic clr_i,
  input  logic ch_en_i,
  input  logic glb_en_i,
  input  logic level_i,
  input  logic msg_en_i,
  input  logic sts_clr_i,
  output logic sts_o,
  output logic drive_nxt_o,
  output logic push_o
);
  logic msg_en_q;
  logic sts_d;
  logic edge_hit;
  logic drop;

  always_comb begin
    drop     = clr_i | ~ch_en_i | ~glb_en_i | sts_clr_i | (msg_en_i & ~msg_en_q);
    sts_d    = sts_o;
    edge_hit = 1'b0;
    push_o   = 1'b0;
    if (drop) begin
      sts_d = 1'b0;
    end else if (fire_i) begin
      if (msg_en_i) begin
        push_o = 1'b1;
      end else if (level_i) begin
        sts_d = 1'b1;
      end else begin
        sts_d    = 1'b0;
        edge_hit = 1'b1;
      end
    end
    drive_nxt_o = sts_d | edge_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_o    <= 1'b0;
      msg_en_q <= 1'b0;
    end else begin
      sts_o    <= sts_d;
      msg_en_q <= msg_en_i;
    end
  end
endmodule

// File: rtl/tir_line_mux.sv
module tir_line_mux #(
  parameter int NCH    = 3,
  parameter int NLINES = 24,
  parameter int RW     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    drive_nxt_i,
  input  logic [NCH*RW-1:0] route_i,
  input  logic              legacy_i,
  input  logic              pit_in_i,
  input  logic              rtc_in_i,
  output logic [NLINES-1:0] irq_o
);
  import tir_pkg::*;

  logic [NLINES-1:0] line_d;
  logic [RW-1:0]     eff [NCH];

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      eff[c] = route_i[c*RW +: RW];
      if (legacy_i && c == 0) eff[c] = RW'(LEG_PIT_LINE);
      if (legacy_i && c == 1) eff[c] = RW'(LEG_RTC_LINE);
    end
  end

  always_comb begin
    line_d = '0;
    for (int l = 0; l < NLINES; l++) begin
      for (int c = 0; c < NCH; c++) begin
        if (drive_nxt_i[c] && eff[c] == RW'(l)) line_d[l] = 1'b1;
      end
    end
    if (!legacy_i) begin
      line_d[LEG_PIT_LINE] = line_d[LEG_PIT_LINE] | pit_in_i;
      line_d[LEG_RTC_LINE] = line_d[LEG_RTC_LINE] | rtc_in_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= '0;
    else     irq_o <= line_d;
  end
endmodule

// File: rtl/tir_msg_q.sv
module tir_msg_q #(
  parameter int NCH = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NCH-1:0]            push_i,
  input  tir_pkg::msg_t [NCH-1:0]   pay_i,
  input  logic                      ready_i,
  output logic                      valid_o,
  output logic [31:0]               addr_o,
  output logic [31:0]               data_o
);
  import tir_pkg::*;
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1;

  msg_t          slot_q [NCH];
  logic [NCH-1:0] pend_q;
  logic [NCH-1:0] take_mask;
  logic [SW-1:0]  sel;
  logic           found;
  logic           take;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int c = 0; c < NCH; c++) begin
      if (pend_q[c] && !found) begin
        found = 1'b1;
        sel   = SW'(c);
      end
    end
    take      = found && (!valid_o || ready_i);
    take_mask = '0;
    if (take) take_mask[sel] = 1'b1;
  end

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (push_i[g]) slot_q[g] <= pay_i[g];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      valid_o <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
    end else begin
      pend_q <= (pend_q & ~take_mask) | push_i;
      if (take) begin
        valid_o <= 1'b1;
        addr_o  <= slot_q[sel].addr;
        data_o  <= slot_q[sel].data;
      end else if (ready_i) begin
        valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tir_router.sv
module tir_router #(
  parameter int  NCH    = 3,
  parameter int  NLINES = 24,
  localparam int RW     = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    fire_i,
  input  logic [NCH-1:0]    clr_i,
  input  logic [NCH-1:0]    ch_en_i,
  input  logic [NCH-1:0]    level_i,
  input  logic [NCH-1:0]    msg_en_i,
  input  logic [NCH*RW-1:0] route_i,
  input  logic [NCH*32-1:0] msg_addr_i,
  input  logic [NCH*32-1:0] msg_data_i,
  input  logic              glb_en_i,
  input  logic              legacy_i,
  input  logic              pit_in_i,
  input  logic              rtc_in_i,
  input  logic              sts_wr_i,
  input  logic [NCH-1:0]    sts_wdata_i,
  input  logic              msg_ready_i,
  output logic [NLINES-1:0] irq_o,
  output logic [NCH-1:0]    sts_o,
  output logic              pit_en_o,
  output logic              msg_valid_o,
  output logic [31:0]       msg_addr_o,
  output logic [31:0]       msg_data_o
);
  import tir_pkg::*;

  logic [NCH-1:0] drive_nxt;
  logic [NCH-1:0] push;
  msg_t [NCH-1:0] pay;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      assign pay[g].addr = msg_addr_i[g*32 +: 32];
      assign pay[g].data = msg_data_i[g*32 +: 32];
      tir_chan u_chan (
        .clk         (clk),
        .rst         (rst),
        .fire_i      (fire_i[g]),
        .clr_i       (clr_i[g]),
        .ch_en_i     (ch_en_i[g]),
        .glb_en_i    (glb_en_i),
        .level_i     (level_i[g]),
        .msg_en_i    (msg_en_i[g]),
        .sts_clr_i   (sts_wr_i & sts_wdata_i[g] & sts_o[g]),
        .sts_o       (sts_o[g]),
        .drive_nxt_o (drive_nxt[g]),
        .push_o      (push[g])
      );
    end
  endgenerate

  tir_line_mux #(.NCH(NCH), .NLINES(NLINES), .RW(RW)) u_mux (
    .clk         (clk),
    .rst         (rst),
    .drive_nxt_i (drive_nxt),
    .route_i     (route_i),
    .legacy_i    (legacy_i),
    .pit_in_i    (pit_in_i),
    .rtc_in_i    (rtc_in_i),
    .irq_o       (irq_o)
  );

  tir_msg_q #(.NCH(NCH)) u_msgq (
    .clk     (clk),
    .rst     (rst),
    .push_i  (push),
    .pay_i   (pay),
    .ready_i (msg_ready_i),
    .valid_o (msg_valid_o),
    .addr_o  (msg_addr_o),
    .data_o  (msg_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) pit_en_o <= 1'b1;
    else     pit_en_o <= ~legacy_i;
  end
endmodule

// File: rtl/tir_router_chk.sv
module tir_router_chk #(
  parameter int NCH    = 3,
  parameter int NLINES = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              glb_en_i,
  input logic              legacy_i,
  input logic              sts_wr_i,
  input logic [NCH-1:0]    sts_wdata_i,
  input logic [NCH-1:0]    msg_en_i,
  input logic              msg_ready_i,
  input logic [NLINES-1:0] irq_o,
  input logic [NCH-1:0]    sts_o,
  input logic              pit_en_o,
  input logic              msg_valid_o,
  input logic [31:0]       msg_addr_o,
  input logic [31:0]       msg_data_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (irq_o == '0 && sts_o == '0 && pit_en_o && !msg_valid_o));

  // R10
  pit_enable_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pit_en_o == !$past(legacy_i)));

  // R6
  global_off_chk: assert property (@(posedge clk) disable iff (rst)
    !glb_en_i |=> (sts_o == '0));

  // R7
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    sts_wr_i |=> ((sts_o & $past(sts_wdata_i & sts_o)) == '0));

  // R11
  msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_valid_o && !msg_ready_i) |=>
      (msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o)));

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_msg
      // R9
      msg_mode_sts_chk: assert property (@(posedge clk) disable iff (rst)
        msg_en_i[g] |=> !sts_o[g]);
    end
  endgenerate
endmodule

bind tir_router tir_router_chk #(.NCH(NCH), .NLINES(NLINES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .glb_en_i    (glb_en_i),
  .legacy_i    (legacy_i),
  .sts_wr_i    (sts_wr_i),
  .sts_wdata_i (sts_wdata_i),
  .msg_en_i    (msg_en_i),
  .msg_ready_i (msg_ready_i),
  .irq_o       (irq_o),
  .sts_o       (sts_o),
  .pit_en_o    (pit_en_o),
  .msg_valid_o (msg_valid_o),
  .msg_addr_o  (msg_addr_o),
  .msg_data_o  (msg_data_o)
);

// File: tb/tir_router_test.sv
module tir_router_test;
  localparam int NCH = 3;
  localparam int NL  = 24;
  localparam int RW  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0]    fire = '0, clr = '0, ch_en = '0, level = '0, msg_en = '0, wdata = '0;
  logic [NCH*RW-1:0] route = '0;
  logic [NCH*32-1:0] maddr, mdata;
  logic glb = 0, legacy = 0, pit = 0, rtc = 0, swr = 0, ready = 0;
  logic [NL-1:0]  irq;
  logic [NCH-1:0] sts;
  logic pit_en, mv;
  logic [31:0] ma, md;

  always #2.5 clk = ~clk;

  tir_router #(.NCH(NCH), .NLINES(NL)) uut (
    .clk(clk), .rst(rst), .fire_i(fire), .clr_i(clr), .ch_en_i(ch_en),
    .level_i(level), .msg_en_i(msg_en), .route_i(route),
    .msg_addr_i(maddr), .msg_data_i(mdata), .glb_en_i(glb),
    .legacy_i(legacy), .pit_in_i(pit), .rtc_in_i(rtc), .sts_wr_i(swr),
    .sts_wdata_i(wdata), .msg_ready_i(ready), .irq_o(irq), .sts_o(sts),
    .pit_en_o(pit_en), .msg_valid_o(mv), .msg_addr_o(ma), .msg_data_o(md)
  );

  int n_chk = 0, n_bad = 0, cycles = 0;
  string phase = "R1";
  logic done = 1'b0;

  // reference model state
  logic [NL-1:0]  m_irq;
  logic [NCH-1:0] m_sts, m_men, m_pend;
  logic m_pit, m_mv;
  logic [31:0] m_ma, m_md;
  logic [31:0] s_addr [NCH];
  logic [31:0] s_data [NCH];

  always @(posedge clk) begin
    logic [NCH-1:0] nsts, drv, psh;
    int sel;
    if (rst) begin
      m_irq = '0; m_sts = '0; m_men = '0; m_pend = '0;
      m_pit = 1; m_mv = 0; m_ma = 0; m_md = 0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        logic drop;
        drop = clr[c] || !ch_en[c] || !glb || (swr && wdata[c] && m_sts[c])
               || (msg_en[c] && !m_men[c]);
        nsts[c] = m_sts[c]; drv[c] = 0; psh[c] = 0;
        if (drop) nsts[c] = 0;
        else if (fire[c]) begin
          if (msg_en[c]) psh[c] = 1;
          else if (level[c]) nsts[c] = 1;
          else begin nsts[c] = 0; drv[c] = 1; end
        end
        drv[c] = drv[c] | nsts[c];
      end
      sel = -1;
      for (int c = NCH-1; c >= 0; c--) if (m_pend[c]) sel = c;
      if (sel >= 0 && (!m_mv || ready)) begin
        m_mv = 1; m_ma = s_addr[sel]; m_md = s_data[sel]; m_pend[sel] = 0;
      end else if (ready) m_mv = 0;
      for (int c = 0; c < NCH; c++) if (psh[c]) begin
        m_pend[c] = 1; s_addr[c] = maddr[c*32 +: 32]; s_data[c] = mdata[c*32 +: 32];
      end
      m_irq = '0;
      for (int c = 0; c < NCH; c++) begin
        int ln;
        ln = int'(route[c*RW +: RW]);
        if (legacy && c == 0) ln = 0;
        if (legacy && c == 1) ln = 8;
        if (drv[c] && ln < NL) m_irq[ln] = 1;
      end
      if (!legacy) begin
        m_irq[0] = m_irq[0] | pit;
        m_irq[8] = m_irq[8] | rtc;
      end
      m_sts = nsts; m_pit = !legacy; m_men = msg_en;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison with the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(irq == m_irq, {phase, " irq"}, 64'(irq), 64'(m_irq));
      chk(sts == m_sts, {phase, " sts"}, 64'(sts), 64'(m_sts));
      chk(pit_en == m_pit, {phase, " pit_en"}, 64'(pit_en), 64'(m_pit));
      chk(mv == m_mv, {phase, " msg_valid"}, 64'(mv), 64'(m_mv));
      if (mv && m_mv) chk({ma, md} == {m_ma, m_md}, {phase, " msg payload"}, {ma, md}, {m_ma, m_md});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<50000", cycles);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_fire(input logic [NCH-1:0] f);
    fire = f; step(1); fire = '0;
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      maddr[c*32 +: 32] = 32'h1000_0000 + 32'(c * 16);
      mdata[c*32 +: 32] = 32'h0000_00A0 + 32'(c);
    end
    step(3); rst = 0; step(1);
    // R1: reset state
    chk(irq == '0 && sts == '0 && pit_en && !mv, "R1 reset", {irq, sts, pit_en, mv}, 64'h2);

    phase = "R2";
    glb = 1; ch_en = 3'b111; level = 3'b101;
    route = {5'd3, 5'd5, 5'd3};
    step(1);
    pulse_fire(3'b001);
    chk(irq[3] && sts[0], "R2 level set", {irq[3], sts[0]}, 2'b11);
    step(2);
    chk(irq[3], "R2 level held", irq[3], 1);

    phase = "R3";
    pulse_fire(3'b010);
    chk(irq[5] && !sts[1], "R3 edge pulse", {irq[5], sts[1]}, 2'b10);
    step(1);
    chk(!irq[5], "R3 pulse one cycle", irq[5], 0);

    phase = "R4";
    pulse_fire(3'b100);
    clr = 3'b001; step(1); clr = '0;
    chk(irq[3] && sts == 3'b100, "R4 shared line OR", {irq[3], sts}, 4'b1100);

    phase = "R7";
    swr = 1; wdata = 3'b011; step(1); swr = 0;
    chk(sts == 3'b100 && irq[3], "R7 clear of unset bits ignored", {irq[3], sts}, 4'b1100);
    swr = 1; wdata = 3'b111; step(1); swr = 0; wdata = '0;
    chk(sts == 3'b000 && !irq[3], "R7 w1c clears", {irq[3], sts}, 0);

    phase = "R6";
    pulse_fire(3'b001);
    ch_en = 3'b110; step(1);
    chk(!sts[0] && !irq[3], "R6 disable drops", {irq[3], sts[0]}, 0);
    ch_en = 3'b111;
    fire = 3'b001; clr = 3'b001; step(1); fire = '0; clr = '0;
    chk(!sts[0] && !irq[3], "R6 clear beats fire", {irq[3], sts[0]}, 0);

    phase = "R10";
    pit = 1; rtc = 1; step(1);
    chk(irq[0] && irq[8], "R10 pass-through", {irq[0], irq[8]}, 2'b11);
    legacy = 1; step(1);
    chk(!irq[0] && !irq[8] && !pit_en, "R10 blocked in takeover", {irq[0], irq[8], pit_en}, 0);

    phase = "R5";
    level = 3'b111;
    pulse_fire(3'b011);
    chk(irq[0] && irq[8] && !irq[3] && !irq[5], "R5 legacy routing", 64'(irq), 64'h101);
    clr = 3'b011; step(1); clr = '0;
    chk(!irq[0] && !irq[8], "R5 legacy clear", {irq[0], irq[8]}, 0);
    legacy = 0; step(1);
    chk(irq[0] && irq[8] && pit_en, "R10 leave takeover", {irq[0], irq[8], pit_en}, 3'b111);
    pit = 0; rtc = 0; level = 3'b101; step(1);

    phase = "R9";
    pulse_fire(3'b100);
    chk(sts[2] && irq[3], "R9 pre", {sts[2], irq[3]}, 2'b11);
    msg_en = 3'b101; step(1);
    chk(!sts[2] && !irq[3], "R9 msg enable drops", {sts[2], irq[3]}, 0);

    phase = "R8";
    ready = 0;
    pulse_fire(3'b101);
    step(1);
    chk(mv && ma == 32'h1000_0000 && md == 32'hA0, "R8 first message", {ma, md}, {32'h1000_0000, 32'hA0});
    chk(sts == '0 && irq == '0, "R8 no line", 64'(irq), 0);
    phase = "R11";
    step(3);
    chk(mv && ma == 32'h1000_0000, "R11 held under stall", ma, 32'h1000_0000);
    ready = 1; step(1);
    chk(mv && ma == 32'h1000_0020 && md == 32'hA2, "R11 second channel next", {ma, md}, {32'h1000_0020, 32'hA2});
    step(1);
    chk(!mv, "R11 drained", mv, 0);
    ready = 0;
    mdata[0 +: 32] = 32'h55;
    pulse_fire(3'b001);
    mdata[0 +: 32] = 32'h66;
    pulse_fire(3'b001);
    step(2);
    ready = 1; step(1);
    chk(!mv || md == 32'h66, "R11 coalesced payload", md, 32'h66);
    step(2); ready = 0;

    phase = "R6g";
    msg_en = '0; step(1);
    pulse_fire(3'b001);
    glb = 0; step(1);
    chk(sts == '0 && !irq[3], "R6 global off", {irq[3], sts}, 0);
    step(2);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule